// File: doc/BRIEF.md
# BCH Syndrome Expansion Unit

This unit takes the partial syndrome values that a BCH remainder stage leaves for one sector. From them it builds the complete set of 2t syndromes over GF(2^13), where t is the selected correction strength. The partial values arrive as 16-bit halves packed into 32-bit words. Each odd syndrome comes from summing powers of the primitive element, one for every set bit of its partial value. Each even syndrome is the square of the syndrome at half its index.

The field uses the primitive polynomial x^13 + x^4 + x^3 + x + 1, so the code length is 8191. The field arithmetic is built from combinational multiply and square functions. The unit holds no lookup memory.

A start pulse latches the strength, clears every stored syndrome and begins a run. The run takes 13 cycles for each odd syndrome and one cycle for each even syndrome. A done flag then rises and stays high until the next start. A downstream locator solver reads the results through an indexed combinational read port.

Top module: `syn_expand`

## Requirements
- R1: While reset is asserted and after it is released, `done` is low and every read index returns zero.
- R2: `t_sel` is sampled only on a `start` cycle. Its codes are 0→t=2, 1→t=4, 2→t=8, 3→t=12 and 4→t=24. Codes 5, 6 and 7 select t=2. Changing `t_sel` during a run has no effect.
- R3: Partial value k (0 ≤ k < t) is bits [13:0]... more precisely, it is the low 13 bits of the 16-bit half at `part_words[16k +: 16]`. That places it in word k/2: the upper half when k is odd and the lower half when k is even. Bits 15:13 of every half are ignored. Partial value k feeds syndrome index 2k+1. `part_words` must be held stable through a run.
- R4: The odd syndrome S_i, for i = 2k+1, is the XOR of alpha^((i·j) mod 8191) over every bit j (0 to 12) that is set in partial value k.
- R5: The even syndrome S_i, for i = 2, 4, …, 2t, is zero when S_(i/2) is zero. Otherwise it is alpha^((2·log S_(i/2)) mod 8191).
- R6: Count edges n from the start edge, which is n=0. S_(2k+1) becomes readable after edge n = 13(k+1) and reads zero before that.
- R7: S_(2e), for e = 1..t, becomes readable after edge n = 13t + e and reads zero before that.
- R8: `done` is low after the start edge. It rises after edge n = 14t+1 and holds until the next `start`.
- R9: A `start` clears all stored syndromes at its edge and restarts the run, even when it arrives during a run.
- R10: `rd_data` shows the entry at `rd_idx` in the same cycle. Index 0, indices above 2t and indices above 48 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a new expansion and clears stored results |
| t_sel | input | 3 | Correction strength code |
| part_words | input | 384 | Packed partial values, 16 bits each, partial k at bit 16k |
| rd_idx | input | 6 | Syndrome index to read |
| rd_data | output | 13 | Syndrome value at `rd_idx` |
| done | output | 1 | High once all 2t syndromes are valid |

## Verification
Every result has a fixed due edge counted from the start edge. Odd syndrome 2k+1 is due at 13(k+1), even syndrome 2e at 13t+e, and `done` at 14t+1. The bench counts edges from the start edge and samples at each falling edge. It moves the read index on every cycle and checks both the value and the zero that must be read before the due edge, so an early or late result is caught in the exact cycle. After a start, and once a run ends, it sweeps every index to check the clearing and the zero reads outside the valid range.

// File: rtl/syn_exp_pkg.sv
package syn_exp_pkg;
  localparam int GF_M = 13;
  localparam logic [GF_M-1:0] GF_RED = 13'h001B;

  typedef logic [GF_M-1:0] gf_t;
  typedef enum logic [1:0] {PH_IDLE, PH_ODD, PH_EVEN, PH_FIN} phase_t;

  // multiply by alpha and reduce by the primitive polynomial
  function automatic gf_t gf_mulx(gf_t a);
    return {a[GF_M-2:0], 1'b0} ^ (a[GF_M-1] ? GF_RED : '0);
  endfunction

  function automatic gf_t gf_mul(gf_t a, gf_t b);
    gf_t r = '0;
    gf_t s = a;
    for (int i = 0; i < GF_M; i++) begin
      if (b[i]) r = r ^ s;
      s = gf_mulx(s);
    end
    return r;
  endfunction

  function automatic gf_t gf_sq(gf_t a);
    return gf_mul(a, a);
  endfunction

  function automatic logic [4:0] strength_of(logic [2:0] sel);
    case (sel)
      3'd1:    return 5'd4;
      3'd2:    return 5'd8;
      3'd3:    return 5'd12;
      3'd4:    return 5'd24;
      default: return 5'd2;
    endcase
  endfunction
endpackage

// File: rtl/syn_part_pick.sv
module syn_part_pick #(
  parameter int M      = 13,
  parameter int T_MAX  = 24,
  parameter int HALF_W = 16,
  parameter int K_W    = 5
) (
  input  logic [T_MAX*HALF_W-1:0] part_words,
  input  logic [K_W-1:0]          k_idx,
  output logic [M-1:0]            partial
);
  logic [HALF_W-1:0] halves [T_MAX];
  logic [T_MAX*(HALF_W-M)-1:0] hi_unused;

  for (genvar h = 0; h < T_MAX; h++) begin : g_half
    assign halves[h] = part_words[h*HALF_W +: HALF_W];
    assign hi_unused[h*(HALF_W-M) +: (HALF_W-M)] = halves[h][HALF_W-1:M];
  end

  logic ign_unused;
  assign ign_unused = ^hi_unused;

  always_comb begin
    partial = '0;
    if (int'(k_idx) < T_MAX) partial = halves[k_idx][M-1:0];
  end
endmodule

// File: rtl/syn_odd_acc.sv
module syn_odd_acc import syn_exp_pkg::*; #(
  parameter int M = GF_M
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init,
  input  logic         step,
  input  logic         last,
  input  logic         bit_in,
  output logic [M-1:0] acc_out
);
  logic [M-1:0] acc_q, pw_q, beta_q;

  assign acc_out = acc_q ^ (bit_in ? pw_q : '0);

  always_ff @(posedge clk) begin
    if (!rst_n || init) begin
      acc_q  <= '0;
      pw_q   <= M'(1);
      beta_q <= M'(2);
    end else if (step) begin
      if (last) begin
        acc_q  <= '0;
        pw_q   <= M'(1);
        beta_q <= gf_mulx(gf_mulx(beta_q));
      end else begin
        acc_q <= acc_out;
        pw_q  <= gf_mul(pw_q, beta_q);
      end
    end
  end
endmodule

// File: rtl/syn_store.sv
module syn_store #(
  parameter int M     = 13,
  parameter int N_SYN = 48,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [M-1:0]     wr_data,
  input  logic [IDX_W-1:0] src_idx,
  output logic [M-1:0]     src_val,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [M-1:0]     rd_data,
  output logic             any_nz
);
  logic [M-1:0] mem [N_SYN+1];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      for (int i = 0; i <= N_SYN; i++) mem[i] <= '0;
    end else if (wr_en && (int'(wr_idx) <= N_SYN)) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign src_val = (int'(src_idx) <= N_SYN) ? mem[src_idx] : '0;
  assign rd_data = (int'(rd_idx) <= N_SYN) ? mem[rd_idx] : '0;

  always_comb begin
    any_nz = 1'b0;
    for (int i = 0; i <= N_SYN; i++) any_nz = any_nz | (|mem[i]);
  end
endmodule

// File: rtl/syn_expand.sv
module syn_expand import syn_exp_pkg::*; #(
  parameter int M      = GF_M,
  parameter int T_MAX  = 24,
  parameter int HALF_W = 16,
  parameter int IDX_W  = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [2:0]              t_sel,
  input  logic [T_MAX*HALF_W-1:0] part_words,
  input  logic [IDX_W-1:0]        rd_idx,
  output logic [M-1:0]            rd_data,
  output logic                    done
);
  localparam int N_SYN = 2 * T_MAX;
  localparam int TQ_W  = IDX_W - 1;
  localparam int BIT_W = $clog2(M);
  localparam int K_W   = $clog2(T_MAX);

  phase_t           phase;
  logic [TQ_W-1:0]  t_q, e_q;
  logic [K_W-1:0]   k_q;
  logic [BIT_W-1:0] bit_q;
  logic             done_q;

  logic [M-1:0]     partial, acc_out, src_val, wr_data;
  logic [IDX_W-1:0] wr_idx, src_idx;
  logic             last_bit, last_k, odd_step, odd_wr, even_wr, wr_en;
  logic             any_nz, ev_src_zero;

  assign last_bit    = (bit_q == BIT_W'(M-1));
  assign last_k      = (k_q == K_W'(t_q - TQ_W'(1)));
  assign odd_step    = (phase == PH_ODD) && !start;
  assign odd_wr      = odd_step && last_bit;
  assign even_wr     = (phase == PH_EVEN) && !start;
  assign wr_en       = odd_wr || even_wr;
  assign src_idx     = IDX_W'(e_q);
  assign wr_idx      = odd_wr ? IDX_W'({k_q, 1'b1}) : IDX_W'({e_q, 1'b0});
  assign wr_data     = odd_wr ? acc_out : gf_sq(src_val);
  assign ev_src_zero = (phase == PH_EVEN) && (src_val == '0);
  assign done        = done_q;

  syn_part_pick #(.M(M), .T_MAX(T_MAX), .HALF_W(HALF_W), .K_W(K_W)) u_pick (
    .part_words (part_words),
    .k_idx      (k_q),
    .partial    (partial)
  );

  syn_odd_acc #(.M(M)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .init    (start),
    .step    (odd_step),
    .last    (last_bit),
    .bit_in  (partial[bit_q]),
    .acc_out (acc_out)
  );

  syn_store #(.M(M), .N_SYN(N_SYN), .IDX_W(IDX_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (start),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .src_idx (src_idx),
    .src_val (src_val),
    .rd_idx  (rd_idx),
    .rd_data (rd_data),
    .any_nz  (any_nz)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      t_q    <= '0;
      e_q    <= '0;
      k_q    <= '0;
      bit_q  <= '0;
      done_q <= 1'b0;
    end else if (start) begin
      phase  <= PH_ODD;
      t_q    <= TQ_W'(strength_of(t_sel));
      e_q    <= '0;
      k_q    <= '0;
      bit_q  <= '0;
      done_q <= 1'b0;
    end else begin
      case (phase)
        PH_ODD: begin
          if (last_bit) begin
            bit_q <= '0;
            if (last_k) begin
              phase <= PH_EVEN;
              e_q   <= TQ_W'(1);
            end else begin
              k_q <= k_q + 1'b1;
            end
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end
        PH_EVEN: begin
          if (e_q == t_q) phase <= PH_FIN;
          else            e_q   <= e_q + 1'b1;
        end
        PH_FIN: begin
          done_q <= 1'b1;
          phase  <= PH_IDLE;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/syn_expand_chk.sv
module syn_expand_chk #(
  parameter int M     = 13,
  parameter int IDX_W = 6,
  parameter int TQ_W  = 5,
  parameter int BIT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             done,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic [M-1:0]     wr_data,
  input logic [TQ_W-1:0]  t_q,
  input logic [BIT_W-1:0] bit_q,
  input logic             any_nz,
  input logic             ev_src_zero
);
  a_r9_cleared_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !any_nz);

  a_r8_done_low_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done);

  a_r8_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  a_r6_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx != '0) && (wr_idx <= {t_q, 1'b0}));

  a_r5_even_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ev_src_zero) |-> (wr_data == '0));

  a_r7_done_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(wr_en, 2) && ($past(wr_idx, 2) == {t_q, 1'b0})));

  a_r4_bit_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(bit_q) < M);
endmodule

bind syn_expand syn_expand_chk #(.M(M), .IDX_W(IDX_W), .TQ_W(TQ_W), .BIT_W(BIT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .done        (done),
  .wr_en       (wr_en),
  .wr_idx      (wr_idx),
  .wr_data     (wr_data),
  .t_q         (t_q),
  .bit_q       (bit_q),
  .any_nz      (any_nz),
  .ev_src_zero (ev_src_zero)
);

// File: tb/syn_expand_tb.sv
`timescale 1ns/1ps
module syn_expand_tb;
  localparam int T_MAX = 24, HALF_W = 16, IDX_W = 6, M = 13;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [2:0] t_sel = '0;
  logic [T_MAX*HALF_W-1:0] part_words = '0;
  logic [IDX_W-1:0] rd_idx = '0;
  logic [M-1:0] rd_data;
  logic done;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int exp_val [64];
  logic [31:0] lf = 32'h1234_5678;

  always #4 clk = ~clk;

  syn_expand u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .t_sel(t_sel),
    .part_words(part_words), .rd_idx(rd_idx), .rd_data(rd_data), .done(done)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_bad++;
      $display("FAIL R8 watchdog actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  function automatic int mulx(int v);
    int r = v << 1;
    if ((r & 32'h2000) != 0) r = r ^ 32'h201B;
    return r;
  endfunction

  function automatic int apow(int n);
    int v = 1;
    for (int i = 0; i < n; i++) v = mulx(v);
    return v;
  endfunction

  function automatic int alog(int s);
    int v = 1;
    for (int i = 0; i < 8191; i++) begin
      if (v == s) return i;
      v = mulx(v);
    end
    return 0;
  endfunction

  function automatic int tval(int sel);
    case (sel)
      1: return 4;
      2: return 8;
      3: return 12;
      4: return 24;
      default: return 2;
    endcase
  endfunction

  // reference syndromes from the requirement formulas (R3, R4, R5)
  function automatic void build(int t);
    for (int i = 0; i < 64; i++) exp_val[i] = 0;
    for (int k = 0; k < t; k++) begin
      int pv = int'(part_words[k*16 +: 13]);
      int s = 0;
      for (int j = 0; j < 13; j++)
        if (((pv >> j) & 1) != 0) s = s ^ apow(((2*k+1)*j) % 8191);
      exp_val[2*k+1] = s;
    end
    for (int e = 1; e <= t; e++) begin
      int s = exp_val[e];
      exp_val[2*e] = (s == 0) ? 0 : apow((2*alog(s)) % 8191);
    end
  endfunction

  function automatic int due(int idx, int t);
    if (idx >= 1 && idx <= 2*t-1 && (idx % 2) == 1) return 13*((idx+1)/2);
    if (idx >= 2 && idx <= 2*t && (idx % 2) == 0) return 13*t + idx/2;
    return -1;
  endfunction

  task automatic check(bit ok, string tag, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic string idx_tag(int idx, int t);
    if (due(idx, t) < 0) return "R10";
    return ((idx % 2) == 1) ? "R4/R6" : "R5/R7";
  endfunction

  task automatic fill_lfsr();
    for (int h = 0; h < T_MAX; h++) begin
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      part_words[h*16 +: 16] = lf[15:0];
    end
  endtask

  task automatic run(int sel, int stop_n, bit sweep0, string pre);
    int t;
    @(negedge clk);
    t_sel = 3'(sel); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t_sel = 3'(sel ^ 3);            // R2: later changes must be ignored
    t = tval(sel);
    build(t);
    for (int n = 0; n <= stop_n; n++) begin
      int idx, d, ev;
      if (n > 0) @(negedge clk);
      if (sweep0 && n == 0) begin
        for (int q = 0; q < 64; q++) begin
          rd_idx = IDX_W'(q); #0.05;
          check(rd_data == '0, {pre, " R9 cleared"}, int'(rd_data), 0);
        end
      end
      idx = n % 64;
      rd_idx = IDX_W'(idx); #0.05;
      d = due(idx, t);
      ev = (d >= 0 && n >= d) ? exp_val[idx] : 0;
      check(int'(rd_data) == ev, {pre, " ", idx_tag(idx, t)}, int'(rd_data), ev);
      check(done == (n >= 14*t+1), {pre, " R8 done"}, int'(done), int'(n >= 14*t+1));
    end
    if (stop_n >= 14*t+1) begin
      for (int q = 0; q < 64; q++) begin
        rd_idx = IDX_W'(q); #0.05;
        check(int'(rd_data) == exp_val[q], {pre, " final ", idx_tag(q, t)}, int'(rd_data), exp_val[q]);
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(done == 1'b0, "R1 done in reset", int'(done), 0);
    for (int q = 0; q < 64; q++) begin
      rd_idx = IDX_W'(q); #0.05;
      check(rd_data == '0, "R1 reset contents", int'(rd_data), 0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 1'b0, "R1 done after reset", int'(done), 0);

    // R3: only bits 15:13 set, all syndromes zero (also zero branch of R5)
    for (int h = 0; h < T_MAX; h++) part_words[h*16 +: 16] = 16'hE000;
    run(4, 14*24+3, 1'b1, "R3");

    // single set bit in partial 0, t=2
    part_words = '0;
    part_words[0] = 1'b1;
    run(0, 14*2+3, 1'b0, "R4");

    fill_lfsr();
    run(1, 14*4+3, 1'b0, "R4");

    // R9: interrupted run, then restart with new data and strength
    fill_lfsr();
    run(2, 40, 1'b0, "R9");
    fill_lfsr();
    run(3, 14*12+3, 1'b1, "R9");

    fill_lfsr();
    run(4, 14*24+3, 1'b0, "R5");

    // R2: codes 5..7 select t=2
    fill_lfsr();
    run(6, 14*2+3, 1'b0, "R2");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule